// File: doc/BRIEF.md
# GPIO input debounce filter

This block cleans up the inputs of one bank of general-purpose pins. It sits
between the pads and the logic that reads the pins and detects interrupts.
Each pad is first brought into the core clock domain by a two-flop
synchronizer. A pin whose debounce bit is clear is passed on with no further
delay. A pin whose debounce bit is set goes through its own stability
counter. That counter advances on a slow debounce tick, which stands in for
the separate debounce clock. The filtered level of the pin follows the pad
only after the new level has held for a programmed number of ticks.

The bank has one debounce window, held in an 8-bit time register and shared
by every pin. One register unit is one debounce period of about 31 µs.
Software maps a requested time below 32 µs to 1, a time above 7936 µs to 255,
and any other time t to t/31 − 1. Each pin has its own enable bit. Both
registers are loaded through plain write strobes. The block raises a
clock-request flag whenever any enable bit is set, so the debounce clock can
be gated off while no pin uses it.

Top module: `gpio_debounce`

## Requirements
- R1: A pin whose enable bit is 0 drives `pin_out` with its pad level exactly two clock edges after that level is sampled. The debounce tick has no effect on such a pin.
- R2: A pin whose enable bit is 1 changes `pin_out` only after its synchronized level has differed from the filtered level on T+1 consecutive tick cycles, where T is the time register. With T=0 a single tick suffices, and with T=255 the 256th tick is needed.
- R3: On an enabled pin, any cycle in which the synchronized level matches the filtered level resets that pin's count. A bounce shorter than the window therefore never reaches `pin_out`.
- R4: While no tick arrives and the enables do not change, the output of every enabled pin holds.
- R5: One time value applies to all pins, but each pin counts on its own. Pins that start at different moments switch at different ticks.
- R6: Reset clears the enable register to all zeros, loads the time register with 0x01 and drives `dbclk_req` low.
- R7: `dbclk_req` is the OR of all enable bits. It follows an enable write in the next cycle.
- R8: A write to the time register while a pin is counting keeps that pin's count. From the next tick on, the count is compared with the new value, and a count already at or above the new value releases the pin on that tick.
- R9: Setting a pin's enable bit while its pad is steady causes no change at `pin_out`. Clearing the bit returns the pin to pass-through at once, and any pending count is dropped.
- R10: `time_val` shows the time register. A write through `time_we`/`time_wdata` appears there in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | asynchronous active-low reset |
| tick | input | 1 | one-cycle debounce tick |
| pad_in | input | NPIN | raw pad levels |
| time_we | input | 1 | write strobe for the time register |
| time_wdata | input | TW | new debounce window value |
| en_we | input | 1 | write strobe for the enable register |
| en_wdata | input | NPIN | new per-pin enable mask |
| pin_out | output | NPIN | synchronized, optionally filtered levels |
| time_val | output | TW | current time register |
| en_val | output | NPIN | current enable register |
| dbclk_req | output | 1 | debounce clock request |

## Verification
The checker assumes the pads are held steady while reset is asserted. It also
assumes writes and ticks are synchronous to `clk`. The bench drives every
input at the falling edge and keeps the pads at zero during reset. It brings
out the filter state only through `pin_out` and the register outputs. Bounce
patterns are placed around tick pulses, so the pass-through and hold
properties are exercised at the exact cycles where a count would start or be
reset.

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int NPIN     = 32,
  parameter int TW       = 8,
  parameter int TIME_RST = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [NPIN-1:0] pad_in,
  input  logic            time_we,
  input  logic [TW-1:0]   time_wdata,
  input  logic            en_we,
  input  logic [NPIN-1:0] en_wdata,
  output logic [NPIN-1:0] pin_out,
  output logic [TW-1:0]   time_val,
  output logic [NPIN-1:0] en_val,
  output logic            dbclk_req
);

  localparam logic [TW-1:0] TIME_INIT = TW'(TIME_RST);

  logic [NPIN-1:0] sync1, sync2, filt;
  logic [TW-1:0]   time_q;
  logic [NPIN-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= TIME_INIT;
      en_q   <= '0;
    end else begin
      if (time_we) time_q <= time_wdata;
      if (en_we)   en_q   <= en_wdata;
    end
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic [TW-1:0] cnt;
    logic          lvl;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0;
        lvl <= 1'b0;
      end else if (!en_q[g]) begin
        cnt <= '0;
        lvl <= sync2[g];
      end else if (sync2[g] == lvl) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt >= time_q) begin
          cnt <= '0;
          lvl <= sync2[g];
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end

    assign filt[g] = lvl;
  end

  assign pin_out   = (en_q & filt) | (~en_q & sync2);
  assign time_val  = time_q;
  assign en_val    = en_q;
  assign dbclk_req = |en_q;

endmodule

// File: rtl/gpio_debounce_chk.sv
module gpio_debounce_chk #(
  parameter int NPIN     = 32,
  parameter int TW       = 8,
  parameter int TIME_RST = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic [NPIN-1:0] pad_in,
  input logic            time_we,
  input logic [TW-1:0]   time_wdata,
  input logic            en_we,
  input logic [NPIN-1:0] en_wdata,
  input logic [NPIN-1:0] pin_out,
  input logic [TW-1:0]   time_val,
  input logic [NPIN-1:0] en_val,
  input logic            dbclk_req
);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  assert_passthrough_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (((pin_out ^ $past(pad_in, 2)) & ~en_val) == '0));

  assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && !$past(tick) && en_val == $past(en_val))
      |-> (((pin_out ^ $past(pin_out)) & en_val) == '0));

  assert_reset_state_R6: assert property (@(posedge clk)
    !rst_n |=> (en_val == '0 && time_val == TW'(TIME_RST) && !dbclk_req));

  assert_clk_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> (dbclk_req == (|$past(en_wdata))));

  assert_time_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    time_we |=> (time_val == $past(time_wdata)));

  unused_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (!time_we && age == 2'd3) |=> $stable(time_val));

endmodule

bind gpio_debounce gpio_debounce_chk #(.NPIN(NPIN), .TW(TW), .TIME_RST(TIME_RST)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .pad_in(pad_in),
  .time_we(time_we), .time_wdata(time_wdata), .en_we(en_we), .en_wdata(en_wdata),
  .pin_out(pin_out), .time_val(time_val), .en_val(en_val), .dbclk_req(dbclk_req)
);

// File: tb/test_gpio_debounce.sv
module test_gpio_debounce;
  localparam int NPIN = 32;
  localparam int TW   = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            tick = 1'b0;
  logic [NPIN-1:0] pad_in = '0;
  logic            time_we = 1'b0;
  logic [TW-1:0]   time_wdata = '0;
  logic            en_we = 1'b0;
  logic [NPIN-1:0] en_wdata = '0;
  logic [NPIN-1:0] pin_out;
  logic [TW-1:0]   time_val;
  logic [NPIN-1:0] en_val;
  logic            dbclk_req;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_debounce #(.NPIN(NPIN), .TW(TW)) i_gpio_debounce (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pad_in(pad_in),
    .time_we(time_we), .time_wdata(time_wdata), .en_we(en_we), .en_wdata(en_wdata),
    .pin_out(pin_out), .time_val(time_val), .en_val(en_val), .dbclk_req(dbclk_req)
  );

  // {pad level, tick count[3:0], expected pin 0}; window T=2 -> 3 ticks
  localparam logic [5:0] VEC [10] = '{
    {1'b1, 4'd2, 1'b0}, {1'b0, 4'd0, 1'b0}, {1'b1, 4'd2, 1'b0},
    {1'b1, 4'd1, 1'b1}, {1'b0, 4'd2, 1'b1}, {1'b1, 4'd0, 1'b1},
    {1'b0, 4'd2, 1'b1}, {1'b0, 4'd1, 1'b0}, {1'b1, 4'd1, 1'b0},
    {1'b0, 4'd1, 1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic wr_time(logic [TW-1:0] v);
    time_we = 1'b1; time_wdata = v;
    @(negedge clk);
    time_we = 1'b0;
  endtask

  task automatic wr_en(logic [NPIN-1:0] v);
    en_we = 1'b1; en_wdata = v;
    @(negedge clk);
    en_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R6 reset state
    check("R6 enable", en_val, 32'h0);
    check("R6 time", 32'(time_val), 32'h1);
    check("R6 clkreq", 32'(dbclk_req), 32'h0);
    check("R6 out", pin_out, 32'h0);

    // R1 two-edge pass-through, ticks ignored
    pad_in[5] = 1'b1;
    cyc(1);
    check("R1 one edge", 32'(pin_out[5]), 32'h0);
    cyc(1);
    check("R1 two edges", 32'(pin_out[5]), 32'h1);
    pad_in = 32'h1234_5678;
    ticks(1);
    check("R1 pattern", pin_out, 32'h1234_5678);
    pad_in = '0;
    cyc(2);

    // R7 clock request
    wr_en(32'h8000_0001);
    check("R7 req on", 32'(dbclk_req), 32'h1);
    check("R7 enable value", en_val, 32'h8000_0001);
    wr_en('0);
    check("R7 req off", 32'(dbclk_req), 32'h0);

    // R2/R3 vector table, T=2
    wr_time(8'd2);
    check("R10 time readback", 32'(time_val), 32'h2);
    wr_en(32'h1);
    for (int i = 0; i < 10; i++) begin
      pad_in[0] = VEC[i][5];
      cyc(2);
      ticks(int'(VEC[i][4:1]));
      check($sformatf("R2 R3 vector %0d", i), 32'(pin_out[0]), 32'(VEC[i][0]));
    end

    // R3 single-cycle glitches straddling ticks
    for (int i = 0; i < 5; i++) begin
      pad_in[0] = 1'b1;
      cyc(1);
      pad_in[0] = 1'b0;
      cyc(1);
      ticks(1);
      check("R3 glitch rejected", 32'(pin_out[0]), 32'h0);
    end

    // R4 hold without tick, R2 with T=0
    wr_time(8'd0);
    pad_in[0] = 1'b1;
    cyc(20);
    check("R4 hold no tick", 32'(pin_out[0]), 32'h0);
    ticks(1);
    check("R2 T0 one tick", 32'(pin_out[0]), 32'h1);
    pad_in[0] = 1'b0;
    cyc(2);
    ticks(1);
    check("R2 T0 fall", 32'(pin_out[0]), 32'h0);

    // R5 shared window, independent counts, T=3
    wr_time(8'd3);
    wr_en(32'h3);
    pad_in[1] = 1'b1;
    cyc(2);
    ticks(2);
    pad_in[0] = 1'b1;
    cyc(2);
    ticks(2);
    check("R5 staggered", 32'(pin_out[1:0]), 32'h2);
    ticks(2);
    check("R5 both", 32'(pin_out[1:0]), 32'h3);

    // R8 time rewrite mid-count
    pad_in[1:0] = 2'b00;
    wr_time(8'd0);
    cyc(2);
    ticks(1);
    check("R8 setup", 32'(pin_out[1:0]), 32'h0);
    wr_time(8'd6);
    pad_in[0] = 1'b1;
    cyc(2);
    ticks(4);
    check("R8 before rewrite", 32'(pin_out[0]), 32'h0);
    wr_time(8'd2);
    check("R10 rewrite", 32'(time_val), 32'h2);
    check("R8 no change at write", 32'(pin_out[0]), 32'h0);
    ticks(1);
    check("R8 released", 32'(pin_out[0]), 32'h1);

    // R9 enable transitions
    wr_en(32'h2);
    check("R9 disable steady", 32'(pin_out[0]), 32'h1);
    pad_in[0] = 1'b0;
    cyc(2);
    check("R1 disabled follows", 32'(pin_out[0]), 32'h0);
    wr_en(32'h3);
    check("R9 enable no glitch", 32'(pin_out[0]), 32'h0);
    pad_in[0] = 1'b1;
    cyc(2);
    ticks(1);
    check("R9 counting", 32'(pin_out[0]), 32'h0);
    wr_en(32'h2);
    check("R9 disable drops count", 32'(pin_out[0]), 32'h1);

    // R2 widest window
    wr_en(32'h1);
    wr_time(8'hFF);
    pad_in[0] = 1'b0;
    cyc(2);
    ticks(255);
    check("R2 255 ticks", 32'(pin_out[0]), 32'h1);
    ticks(1);
    check("R2 256 ticks", 32'(pin_out[0]), 32'h0);

    finish_run();
  end
endmodule